// File: doc/BRIEF.md
# 1-Wire Touch Byte Engine

This block is the bit-timing core of a 1-Wire bus master. A single start strobe makes it run eight time slots back to back. In each slot it sends one bit of a byte and, in the same slot, samples the line. The block therefore writes and reads at the same time. Bits leave from the low end of one internal register. Each sampled line value enters at the top end of that register as the register moves right, so after eight slots the register holds the byte seen on the bus.

To read a byte, the host sends 0xFF. Every slot then only pulls the line low briefly, and a device may hold the line low to answer 0. To write, the host sends the data byte and discards the value that comes back. The bus side is an active-high open-drain enable, which pulls the line low when high, and a line input that passes through a two-flop synchronizer. All slot timing is given in microseconds and converted to clock cycles from the clock frequency parameter.

Top module: `onewire_touch_engine`

## Requirements
- R1: After reset, busy_o, done_o and bus_pull_o are 0 and rx_byte_o is 0x00.
- R2: In a slot whose bit is 1, bus_pull_o is high for exactly LOW_US microseconds of clock cycles (default 6 µs), counted from the first cycle of the slot.
- R3: In a slot whose bit is 0, bus_pull_o stays high for exactly SLOT_US microseconds of clock cycles (default 66 µs). This covers the 60 µs minimum for writing a 0.
- R4: bus_pull_o is low during the recovery gap of REC_US microseconds (default 2 µs) after each slot and whenever the engine is idle. Successive slots start exactly (SLOT_US+REC_US) microseconds of cycles apart.
- R5: Bits go out least significant first: slot k (k = 0..7) carries bit k of tx_byte_i.
- R6: Bit k of rx_byte_o is the line level sampled SAMPLE_US microseconds (default 15 µs) into slot k, where 1 means released. With a device that pulls the line low for the bits of a reply byte, the result is tx AND reply. Sending 0xFF therefore returns the reply unchanged.
- R7: done_o pulses high for exactly one cycle, 8*(SLOT_US+REC_US) microseconds of cycles after the start edge. busy_o is high from the cycle after that edge until done_o rises, and is low when done_o is high.
- R8: rx_byte_o changes only in the cycle done_o is high, and keeps its value through a following exchange until that exchange completes.
- R9: A start strobe while busy_o is high has no effect on the running exchange, its timing or its result.
- R10: A start strobe while idle begins slot 0 in the next cycle, with busy_o and bus_pull_o both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an 8-slot exchange (accepted when idle) |
| tx_byte_i | input | 8 | Byte to send, sampled with start_i |
| rx_byte_o | output | 8 | Byte read from the bus |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bus_pull_o | output | 1 | Open-drain enable: 1 pulls the line low |
| bus_line_i | input | 1 | Raw line level (asynchronous) |

## Verification
busy_o and bus_pull_o are due one cycle after the start edge. done_o is due exactly 8*(slot+recovery) cycles after that edge, and the bench counts falling edges from the start edge to that exact number. The bench measures each pull width and the spacing between slot starts on falling clock edges, where every output is stable. It plays a device that answers bits from a reply byte and compares both the bus level it observes and rx_byte_o against tx AND reply. The check that rx_byte_o holds its value falls in the middle of the following exchange, long before that exchange's done pulse.

// File: rtl/owt_pkg.sv
package owt_pkg;
    localparam int unsigned OWT_BITS  = 8;
    localparam int unsigned OWT_IDX_W = $clog2(OWT_BITS);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SLOT    = 2'd1,
        ST_RECOVER = 2'd2
    } owt_state_e;

    typedef struct packed {
        owt_state_e           state;
        logic [OWT_IDX_W-1:0] bit_idx;
        logic                 samp;
        logic                 done;
        logic [OWT_BITS-1:0]  rx;
    } owt_ctl_t;
endpackage

// File: rtl/owt_line_sync.sv
module owt_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign line_o = sync_q[STAGES-1];
endmodule

// File: rtl/owt_slot_timer.sv
module owt_slot_timer #(
    parameter int unsigned LOW_CYC    = 300,
    parameter int unsigned SAMPLE_CYC = 750,
    parameter int unsigned SLOT_CYC   = 3300,
    parameter int unsigned REC_CYC    = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic in_low_o,
    output logic at_sample_o,
    output logic at_slot_end_o,
    output logic at_rec_end_o
);
    localparam int unsigned MAX_CYC = (SLOT_CYC > REC_CYC) ? SLOT_CYC : REC_CYC;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i) cnt_d = '0;
        else       cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign in_low_o      = (cnt_q < CW'(LOW_CYC));
    assign at_sample_o   = (cnt_q == CW'(SAMPLE_CYC));
    assign at_slot_end_o = (cnt_q == CW'(SLOT_CYC - 1));
    assign at_rec_end_o  = (cnt_q == CW'(REC_CYC - 1));

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAX_CYC)) else $error("slot counter overran"); // R4
endmodule

// File: rtl/owt_touch_shift.sv
module owt_touch_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         shift_in_i,
    output logic         lsb_o,
    output logic [W-1:0] data_o
);
    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load_i)       data_d = load_val_i;
        else if (shift_i) data_d = {shift_in_i, data_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign lsb_o  = data_q[0];
    assign data_o = data_q;

    AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i)) else $error("load and shift together"); // R9
endmodule

// File: rtl/onewire_touch_engine.sv
module onewire_touch_engine
    import owt_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned LOW_US      = 6,
    parameter int unsigned SAMPLE_US   = 15,
    parameter int unsigned SLOT_US     = 66,
    parameter int unsigned REC_US      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [OWT_BITS-1:0] tx_byte_i,
    output logic [OWT_BITS-1:0] rx_byte_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                bus_pull_o,
    input  logic                bus_line_i
);
    localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int unsigned LOW_CYC    = LOW_US * CYC_PER_US;
    localparam int unsigned SAMPLE_CYC = SAMPLE_US * CYC_PER_US;
    localparam int unsigned SLOT_CYC   = SLOT_US * CYC_PER_US;
    localparam int unsigned REC_CYC    = REC_US * CYC_PER_US;
    localparam logic [OWT_IDX_W-1:0] LAST_IDX = OWT_IDX_W'(OWT_BITS - 1);

    owt_ctl_t ctl_d, ctl_q;

    logic line_s;
    logic in_low, at_sample, at_slot_end, at_rec_end;
    logic tmr_clr;
    logic sh_load, sh_shift, tx_bit;
    logic [OWT_BITS-1:0] sh_data;

    owt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (bus_line_i),
        .line_o (line_s)
    );

    owt_slot_timer #(
        .LOW_CYC    (LOW_CYC),
        .SAMPLE_CYC (SAMPLE_CYC),
        .SLOT_CYC   (SLOT_CYC),
        .REC_CYC    (REC_CYC)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (tmr_clr),
        .in_low_o      (in_low),
        .at_sample_o   (at_sample),
        .at_slot_end_o (at_slot_end),
        .at_rec_end_o  (at_rec_end)
    );

    owt_touch_shift #(.W(OWT_BITS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_val_i (tx_byte_i),
        .shift_i    (sh_shift),
        .shift_in_i (ctl_q.samp),
        .lsb_o      (tx_bit),
        .data_o     (sh_data)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.done = 1'b0;
        tmr_clr  = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                tmr_clr = 1'b1;
                if (start_i) begin
                    sh_load       = 1'b1;
                    ctl_d.bit_idx = '0;
                    ctl_d.state   = ST_SLOT;
                end
            end
            ST_SLOT: begin
                if (at_sample) ctl_d.samp = line_s;
                if (at_slot_end) begin
                    sh_shift    = 1'b1;
                    tmr_clr     = 1'b1;
                    ctl_d.state = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (at_rec_end) begin
                    tmr_clr = 1'b1;
                    if (ctl_q.bit_idx == LAST_IDX) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.done  = 1'b1;
                        ctl_d.rx    = sh_data;
                    end else begin
                        ctl_d.bit_idx = ctl_q.bit_idx + OWT_IDX_W'(1);
                        ctl_d.state   = ST_SLOT;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, bit_idx: '0, samp: 1'b1, done: 1'b0, rx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_pull_o = (ctl_q.state == ST_SLOT) && (in_low || !tx_bit);
    assign busy_o     = (ctl_q.state != ST_IDLE);
    assign done_o     = ctl_q.done;
    assign rx_byte_o  = ctl_q.rx;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o) else $error("done while busy"); // R7
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_pull_o) else $error("pull while idle"); // R4
    AST_RX_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte_o) |-> done_o) else $error("rx moved without done"); // R8
    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && bus_pull_o)) else $error("start not taken"); // R10
endmodule

// File: tb/onewire_touch_engine_test.sv
module onewire_touch_engine_test;
    localparam int CLK_HZ = 4_000_000;
    localparam int CPU    = CLK_HZ / 1_000_000;
    localparam int LOWC   = 6 * CPU;
    localparam int SLOTC  = 66 * CPU;
    localparam int RECC   = 2 * CPU;
    localparam int PERIOD = SLOTC + RECC;
    localparam int BYTEC  = 8 * PERIOD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [7:0] tx_i = 8'h00;
    logic [7:0] rx_o;
    logic busy_o, done_o, pull_o;
    logic slave_low = 1'b0;
    logic line;

    int errors = 0;
    int checks = 0;

    logic [7:0] exp_tx = 8'hFF;
    logic [7:0] exp_reply = 8'hFF;
    logic [7:0] obs = 8'h00;
    logic [7:0] prev_rx = 8'h00;
    int mon_idx = 0;
    int cur_slot = 0;
    int cyc = 0;
    int last_rise = 0;
    int hi_cnt = 0;
    int age = 0;
    int slave_cnt = 0;
    logic pull_prev = 1'b0;

    always #5 clk = ~clk;

    assign line = ~(pull_o | slave_low);

    onewire_touch_engine #(.CLK_HZ(CLK_HZ)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tx_byte_i  (tx_i),
        .rx_byte_o  (rx_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .bus_pull_o (pull_o),
        .bus_line_i (line)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Device model and slot monitor, all on falling edges.
    always @(negedge clk) begin
        cyc++;
        age++;
        if (pull_o && !pull_prev) begin
            if (mon_idx > 0) check((cyc - last_rise) == PERIOD, "R4 slot spacing", cyc - last_rise, PERIOD);
            last_rise = cyc;
            cur_slot = mon_idx;
            mon_idx++;
            hi_cnt = 0;
            age = 0;
            if (!exp_reply[cur_slot[2:0]]) slave_cnt = 140;
        end
        if (pull_o) hi_cnt++;
        if (!pull_o && pull_prev) begin
            if (exp_tx[cur_slot[2:0]])
                check(hi_cnt == LOWC, "R2 one-bit pull width", hi_cnt, LOWC);
            else
                check(hi_cnt == SLOTC, "R3 zero-bit pull width", hi_cnt, SLOTC);
        end
        if (age == 100) obs[cur_slot[2:0]] = line;
        if (slave_cnt > 0) begin
            slave_low = 1'b1;
            slave_cnt--;
        end else begin
            slave_low = 1'b0;
        end
        pull_prev = pull_o;
    end

    function automatic logic [7:0] expect_rx(input logic [7:0] t, input logic [7:0] r);
        return t & r;
    endfunction

    task automatic run_byte(input logic [7:0] t, input logic [7:0] r, input bit poke);
        int n;
        bit busy_ok;
        exp_tx = t;
        exp_reply = r;
        mon_idx = 0;
        obs = 8'h00;
        @(negedge clk);
        tx_i = t;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        tx_i = ~t;
        check(busy_o && pull_o, "R10 slot 0 begins", {busy_o, pull_o}, 2'b11);
        n = 0;
        busy_ok = 1'b1;
        while (!done_o && n < BYTEC + 100) begin
            if (poke && (n == 700 || n == PERIOD * 3)) start_i = 1'b1;
            else start_i = 1'b0;
            @(negedge clk);
            n++;
            if (n == 1000) check(rx_o == prev_rx, "R8 rx held during next exchange", rx_o, prev_rx);
            if (!done_o && !busy_o) busy_ok = 1'b0;
        end
        start_i = 1'b0;
        check(n == BYTEC, "R7 done timing", n, BYTEC);
        check(busy_ok && !busy_o, "R7 busy span", {busy_ok, busy_o}, 2'b10);
        check(rx_o == expect_rx(t, r), "R6 received byte", rx_o, expect_rx(t, r));
        check(obs == expect_rx(t, r), "R5 bus bit order", obs, expect_rx(t, r));
        if (poke) check(rx_o == expect_rx(t, r) && n == BYTEC, "R9 start while busy ignored", rx_o, expect_rx(t, r));
        @(negedge clk);
        check(!done_o, "R7 done single cycle", done_o, 0);
        check(rx_o == expect_rx(t, r), "R8 rx held after done", rx_o, expect_rx(t, r));
        prev_rx = rx_o;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [7:0] rt, rr;
        seed = 32'd20240611;
        rt = 8'($urandom(seed));
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !pull_o && rx_o == 8'h00, "R1 reset state",
              {busy_o, done_o, pull_o, rx_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy_o && !pull_o && rx_o == 8'h00, "R1 idle after reset", {busy_o, pull_o, rx_o}, 0);

        run_byte(8'hFF, 8'hA5, 1'b0);   // read: reply passes through (R6)
        run_byte(8'h3C, 8'hFF, 1'b0);   // write only
        run_byte(8'h00, 8'hFF, 1'b0);   // all zero slots (R3)
        run_byte(8'h01, 8'hFF, 1'b0);   // LSB first (R5)
        run_byte(8'h80, 8'hFF, 1'b0);
        run_byte(8'hFF, 8'h00, 1'b0);
        run_byte(8'h5A, 8'h0F, 1'b1);   // start pulses while busy (R9)
        for (int i = 0; i < 18; i++) begin
            rt = 8'($urandom);
            rr = 8'($urandom);
            run_byte(rt, rr, (i % 4) == 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule